// File: doc/BRIEF.md
# Four-Bank Local Scratchpad Memory

This block is a 32 KB single-cycle scratchpad made of four independent 8 KB banks. Each bank stores 64-bit words and has its own controller. Four requesters share the banks: inbound mesh writes, core load/store, outbound DMA reads and instruction fetch. Each requester can reach any word through one shared byte address. When requesters target different banks, up to four 64-bit accesses complete in the same cycle.

Each port raises a request with an address, a write flag, write data and byte strobes. In the same cycle it gets a grant if it wins its bank. A granted write commits at the clock edge. A granted read returns its word, with a valid flag, on the following cycle. A port that loses holds its request until it is granted. Accesses from any one port therefore complete in the order they were issued.

Top module: `quadBankScratchpad`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every read-valid output is low.
- R2: A granted read raises that port's read-valid exactly one cycle after the grant. The data returned is the word most recently written at that address.
- R3: A granted write updates only the bytes whose strobe bit is set. Strobe bit i covers data bits [8i+7:8i]. All other bytes of the word keep their old value.
- R4: Byte address bits [14:13] select the bank and bits [12:3] select the word within the bank. Bits [2:0] are ignored. The 4096 words are distinct storage locations.
- R5: Requests that target different banks are all granted in the same cycle. Any bank with at least one request grants exactly one port.
- R6: When several ports target one bank, the fixed priority is port 0 (mesh receive), then port 1 (load/store), then port 2 (DMA), then port 3 (fetch). A bank never grants more than one port per cycle.
- R7: A grant goes only to a port that is requesting. A granted write never raises read-valid.
- R8: A request that loses arbitration performs no access in that cycle. A losing write leaves memory unchanged, and a same-cycle read by the winner returns the old word.
- R9: Accesses from one port complete in issue order. A read issued in the cycle after a granted write to the same word returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portReq | input | 4 | Request per port (0 mesh rx, 1 load/store, 2 DMA, 3 fetch) |
| portWe | input | 4 | Write flag per port (1 write, 0 read) |
| portAddr | input | 4x15 | Byte address per port |
| portWdata | input | 4x64 | Write data per port |
| portBe | input | 4x8 | Byte strobes per port |
| portGnt | output | 4 | Grant per port, same cycle as the request |
| portRdValid | output | 4 | Read data valid per port, one cycle after a read grant |
| portRdData | output | 4x64 | Read data per port, meaningful when valid |

## Verification
The assertions check the grant rules on every cycle:
- grants go only to requesting ports;
- each bank grants at most one port and serves any bank that has a request;
- the mesh port always wins, and no port wins over a higher-priority port on its bank;
- read-valid follows a read grant by exactly one cycle.

Only the bench scenarios can show the data behaviour:
- stored contents, byte-strobe merging and address decode;
- that a losing write leaves memory untouched;
- same-port write-then-read ordering.

The bench compares each returned word against a reference memory it keeps itself.

// File: rtl/spadPkg.sv
package spadPkg;
  parameter int SPAD_PORTS = 4;
  parameter int SPAD_BANKS = 4;
  parameter int SPAD_DATA_W = 64;
  parameter int SPAD_WORDS_PER_BANK = 1024;

  localparam int SPAD_PORT_W = $clog2(SPAD_PORTS);
  localparam int SPAD_BANK_W = $clog2(SPAD_BANKS);

  typedef enum logic [SPAD_PORT_W-1:0] {
    PORT_MESH_RX = 0,
    PORT_LDST    = 1,
    PORT_DMA     = 2,
    PORT_FETCH   = 3
  } spadPort_e;

  typedef struct packed {
    logic [SPAD_BANKS-1:0]                  bankEn;
    logic [SPAD_BANKS-1:0]                  bankWe;
    logic [SPAD_BANKS-1:0][SPAD_PORT_W-1:0] bankPort;
    logic [SPAD_PORTS-1:0][SPAD_BANK_W-1:0] portBankQ;
  } spadStrobes_t;
endpackage

// File: rtl/spadArbCtrl.sv
module spadArbCtrl
  import spadPkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [SPAD_PORTS-1:0]            portReq,
  input  logic [SPAD_PORTS-1:0]            portWe,
  input  logic [SPAD_PORTS-1:0][ADDR_W-1:0] portAddr,
  output logic [SPAD_PORTS-1:0]            portGnt,
  output logic [SPAD_PORTS-1:0]            portRdValid,
  output spadStrobes_t                     strobes
);
  logic [SPAD_PORTS-1:0][SPAD_BANK_W-1:0] portBank;
  logic [SPAD_BANKS-1:0]                  bankEn;
  logic [SPAD_BANKS-1:0][SPAD_PORT_W-1:0] bankPort;
  logic [SPAD_BANKS-1:0]                  bankWe;
  logic [SPAD_PORTS-1:0][SPAD_BANK_W-1:0] portBankQ;

  for (genvar p = 0; p < SPAD_PORTS; p++) begin : gBankOf
    assign portBank[p] = portAddr[p][ADDR_W-1 -: SPAD_BANK_W];
  end

  // Fixed priority per bank: scan from lowest priority up so the
  // lowest-numbered requesting port is the last one written.
  always_comb begin
    bankEn   = '0;
    bankPort = '0;
    for (int b = 0; b < SPAD_BANKS; b++) begin
      for (int p = SPAD_PORTS - 1; p >= 0; p--) begin
        if (portReq[p] && (portBank[p] == SPAD_BANK_W'(b))) begin
          bankEn[b]   = 1'b1;
          bankPort[b] = SPAD_PORT_W'(p);
        end
      end
    end
  end

  always_comb begin
    for (int b = 0; b < SPAD_BANKS; b++) begin
      bankWe[b] = bankEn[b] & portWe[bankPort[b]];
    end
    for (int p = 0; p < SPAD_PORTS; p++) begin
      portGnt[p] = portReq[p] && (bankPort[portBank[p]] == SPAD_PORT_W'(p));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portRdValid <= '0;
      portBankQ   <= '0;
    end else begin
      portRdValid <= portGnt & ~portWe;
      portBankQ   <= portBank;
    end
  end

  assign strobes.bankEn    = bankEn;
  assign strobes.bankWe    = bankWe;
  assign strobes.bankPort  = bankPort;
  assign strobes.portBankQ = portBankQ;
endmodule

// File: rtl/spadBankData.sv
module spadBankData
  import spadPkg::*;
#(
  parameter int DATA_W         = 64,
  parameter int WORDS_PER_BANK = 1024,
  parameter int ADDR_W         = 15
) (
  input  logic                                clk,
  input  spadStrobes_t                        strobes,
  input  logic [SPAD_PORTS-1:0][ADDR_W-1:0]   portAddr,
  input  logic [SPAD_PORTS-1:0][DATA_W-1:0]   portWdata,
  input  logic [SPAD_PORTS-1:0][DATA_W/8-1:0] portBe,
  output logic [SPAD_PORTS-1:0][DATA_W-1:0]   portRdData
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int IDX_W = $clog2(WORDS_PER_BANK);

  logic [SPAD_BANKS-1:0][DATA_W-1:0] bankRdWord;

  for (genvar b = 0; b < SPAD_BANKS; b++) begin : gBank
    logic [DATA_W-1:0] mem [WORDS_PER_BANK];
    logic [IDX_W-1:0]  selIdx;
    logic [DATA_W-1:0] selData;
    logic [BYTES-1:0]  selBe;

    always_comb begin
      selIdx  = portAddr[strobes.bankPort[b]][OFF_W +: IDX_W];
      selData = portWdata[strobes.bankPort[b]];
      selBe   = portBe[strobes.bankPort[b]];
    end

    always_ff @(posedge clk) begin
      if (strobes.bankEn[b]) begin
        if (strobes.bankWe[b]) begin
          for (int i = 0; i < BYTES; i++) begin
            if (selBe[i]) mem[selIdx][i*8 +: 8] <= selData[i*8 +: 8];
          end
        end else begin
          bankRdWord[b] <= mem[selIdx];
        end
      end
    end
  end

  for (genvar p = 0; p < SPAD_PORTS; p++) begin : gRet
    assign portRdData[p] = bankRdWord[strobes.portBankQ[p]];
  end
endmodule

// File: rtl/quadBankScratchpad.sv
module quadBankScratchpad
  import spadPkg::*;
#(
  parameter int DATA_W         = SPAD_DATA_W,
  parameter int WORDS_PER_BANK = SPAD_WORDS_PER_BANK,
  parameter int ADDR_W         = SPAD_BANK_W + $clog2(WORDS_PER_BANK) + $clog2(DATA_W / 8)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [SPAD_PORTS-1:0]               portReq,
  input  logic [SPAD_PORTS-1:0]               portWe,
  input  logic [SPAD_PORTS-1:0][ADDR_W-1:0]   portAddr,
  input  logic [SPAD_PORTS-1:0][DATA_W-1:0]   portWdata,
  input  logic [SPAD_PORTS-1:0][DATA_W/8-1:0] portBe,
  output logic [SPAD_PORTS-1:0]               portGnt,
  output logic [SPAD_PORTS-1:0]               portRdValid,
  output logic [SPAD_PORTS-1:0][DATA_W-1:0]   portRdData
);
  spadStrobes_t strobes;

  spadArbCtrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .portReq(portReq), .portWe(portWe),
    .portAddr(portAddr), .portGnt(portGnt), .portRdValid(portRdValid),
    .strobes(strobes)
  );

  spadBankData #(
    .DATA_W(DATA_W), .WORDS_PER_BANK(WORDS_PER_BANK), .ADDR_W(ADDR_W)
  ) data (
    .clk(clk), .strobes(strobes), .portAddr(portAddr),
    .portWdata(portWdata), .portBe(portBe), .portRdData(portRdData)
  );
endmodule

// File: rtl/spadCheck.sv
module spadCheck
  import spadPkg::*;
#(
  parameter int ADDR_W = 15
) (
  input logic                             clk,
  input logic                             rstN,
  input logic [SPAD_PORTS-1:0]            portReq,
  input logic [SPAD_PORTS-1:0]            portWe,
  input logic [SPAD_PORTS-1:0][ADDR_W-1:0] portAddr,
  input logic [SPAD_PORTS-1:0]            portGnt,
  input logic [SPAD_PORTS-1:0]            portRdValid
);
  logic [SPAD_BANKS-1:0][SPAD_PORTS-1:0] bankReqVec;
  logic [SPAD_BANKS-1:0][SPAD_PORTS-1:0] bankGntVec;
  logic [SPAD_PORTS-1:0]                 higherOnBank;

  always_comb begin
    for (int b = 0; b < SPAD_BANKS; b++) begin
      for (int p = 0; p < SPAD_PORTS; p++) begin
        bankReqVec[b][p] = portReq[p] && (portAddr[p][ADDR_W-1 -: SPAD_BANK_W] == SPAD_BANK_W'(b));
        bankGntVec[b][p] = portGnt[p] && (portAddr[p][ADDR_W-1 -: SPAD_BANK_W] == SPAD_BANK_W'(b));
      end
    end
    for (int p = 0; p < SPAD_PORTS; p++) begin
      higherOnBank[p] = 1'b0;
      for (int q = 0; q < p; q++) begin
        if (portReq[q] && (portAddr[q][ADDR_W-1 -: SPAD_BANK_W] == portAddr[p][ADDR_W-1 -: SPAD_BANK_W]))
          higherOnBank[p] = 1'b1;
      end
    end
  end

  AST_MESH_ALWAYS_WINS: assert property (@(posedge clk) disable iff (!rstN)
    portReq[PORT_MESH_RX] |-> portGnt[PORT_MESH_RX]); // R6

  for (genvar b = 0; b < SPAD_BANKS; b++) begin : gBankChk
    AST_ONE_GRANT_PER_BANK: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(bankGntVec[b])); // R6
    AST_BUSY_BANK_SERVED: assert property (@(posedge clk) disable iff (!rstN)
      (|bankReqVec[b]) |-> (|bankGntVec[b])); // R5
  end

  for (genvar p = 0; p < SPAD_PORTS; p++) begin : gPortChk
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
      portGnt[p] |-> portReq[p]); // R7
    AST_NO_WIN_OVER_HIGHER: assert property (@(posedge clk) disable iff (!rstN)
      higherOnBank[p] |-> !portGnt[p]); // R6
    AST_READ_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
      (portGnt[p] && !portWe[p]) |=> portRdValid[p]); // R2
    AST_VALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
      portRdValid[p] |-> $past(portGnt[p] && !portWe[p])); // R7
  end
endmodule

bind quadBankScratchpad spadCheck #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .portReq(portReq), .portWe(portWe),
  .portAddr(portAddr), .portGnt(portGnt), .portRdValid(portRdValid)
);

// File: tb/quadBankScratchpad_test.sv
module quadBankScratchpad_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] req = '0, we = '0;
  logic [NP-1:0][14:0] addr = '0;
  logic [NP-1:0][63:0] wdata = '0;
  logic [NP-1:0][7:0] be = '0;
  logic [NP-1:0] gnt, rdValid;
  logic [NP-1:0][63:0] rdData;

  logic [63:0] model [4096];
  logic [NP-1:0] lastGnt = '0;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  quadBankScratchpad uut (
    .clk(clk), .rstN(rstN), .portReq(req), .portWe(we), .portAddr(addr),
    .portWdata(wdata), .portBe(be), .portGnt(gnt), .portRdValid(rdValid),
    .portRdData(rdData)
  );

  function automatic logic [14:0] mkAddr(int bank, int idx, int off);
    return {bank[1:0], idx[9:0], off[2:0]};
  endfunction

  function automatic logic [NP-1:0] calcGrant(logic [NP-1:0] r, logic [NP-1:0][14:0] a);
    logic [NP-1:0] g = r;
    for (int p = 0; p < NP; p++)
      for (int q = 0; q < p; q++)
        if (r[q] && a[q][14:13] == a[p][14:13]) g[p] = 1'b0;
    return g;
  endfunction

  function automatic logic [63:0] mergeBytes(logic [63:0] oldW, logic [63:0] newW, logic [7:0] s);
    logic [63:0] m = oldW;
    for (int i = 0; i < 8; i++) if (s[i]) m[i*8 +: 8] = newW[i*8 +: 8];
    return m;
  endfunction

  task automatic checkBit(string tag, int p, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s port %0d: actual %b expected %b", tag, p, act, exp);
    end
  endtask

  // Entered just after a negedge with inputs set; leaves at the next negedge.
  task automatic step(string tag);
    logic [NP-1:0] expG;
    logic [NP-1:0] expV;
    logic [NP-1:0][63:0] expD;
    #1;
    expG = calcGrant(req, addr);
    for (int p = 0; p < NP; p++) checkBit({tag, " grant"}, p, gnt[p], expG[p]);
    for (int p = 0; p < NP; p++) begin
      expV[p] = expG[p] && !we[p];
      expD[p] = model[addr[p][14:3]];
    end
    for (int p = 0; p < NP; p++)
      if (expG[p] && we[p]) model[addr[p][14:3]] = mergeBytes(model[addr[p][14:3]], wdata[p], be[p]);
    lastGnt = expG;
    @(posedge clk); #1;
    for (int p = 0; p < NP; p++) begin
      checkBit({tag, " rdValid"}, p, rdValid[p], expV[p]);
      if (expV[p]) begin
        checks++;
        if (rdData[p] !== expD[p]) begin
          fails++;
          $display("FAIL %s data port %0d: actual %h expected %h", tag, p, rdData[p], expD[p]);
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    req = '0; we = '0; be = '0;
  endtask

  initial begin
    while (!done && cyc < 150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, all requirements: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5EED_0042;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    checkBit("R1 in reset", 0, |rdValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkBit("R1 after reset", 0, |rdValid, 1'b0);

    // Fill words 0..7 of every bank: port p writes bank p (R5 parallel).
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < NP; p++) begin
        req[p] = 1; we[p] = 1; be[p] = 8'hFF;
        addr[p] = mkAddr(p, k, 0); wdata[p] = {$urandom, $urandom};
      end
      step("R5 fill");
    end
    idle();

    // R3: partial byte write, then read back.
    req[1] = 1; we[1] = 1; be[1] = 8'h0F; addr[1] = mkAddr(0, 0, 0);
    wdata[1] = 64'hAAAA_BBBB_CCCC_DDDD;
    step("R3 strobe write");
    req[1] = 1; we[1] = 0; step("R3 strobe read");
    we[1] = 1; be[1] = 8'b1010_0101; wdata[1] = 64'h1122_3344_5566_7788;
    step("R3 strobe write2");
    we[1] = 0; step("R3 strobe read2");
    idle();

    // R4: low address bits ignored; high word index in another bank.
    req[2] = 1; we[2] = 1; be[2] = 8'hFF; addr[2] = mkAddr(1, 1000, 5);
    wdata[2] = 64'h0123_4567_89AB_CDEF; step("R4 write");
    we[2] = 0; addr[2] = mkAddr(1, 1000, 2); step("R4 read alias");
    addr[2] = mkAddr(1, 0, 0); step("R4 other word");
    addr[2] = mkAddr(0, 0, 0); step("R4 other bank");
    idle();

    // R6: all four on bank 2; losers hold until granted.
    for (int p = 0; p < NP; p++) begin
      req[p] = 1; we[p] = 0; addr[p] = mkAddr(2, p, 0);
    end
    for (int c = 0; c < 4; c++) begin
      step("R6 priority");
      req = req & ~lastGnt;
    end
    idle();

    // R8: DMA write loses to mesh read on the same word; the read sees old data.
    req[0] = 1; we[0] = 0; addr[0] = mkAddr(3, 5, 0);
    req[2] = 1; we[2] = 1; be[2] = 8'hFF; addr[2] = mkAddr(3, 5, 0);
    wdata[2] = 64'hDEAD_BEEF_0000_0001;
    step("R8 losing write");
    req[0] = 0; step("R8 retry write");
    idle();
    req[0] = 1; addr[0] = mkAddr(3, 5, 0); step("R8 readback");
    idle();

    // R9: same-port write then immediate read, then ordered reads.
    req[3] = 1; we[3] = 1; be[3] = 8'hFF; addr[3] = mkAddr(2, 6, 0);
    wdata[3] = 64'hFEED_FACE_1234_5678; step("R9 write");
    we[3] = 0; step("R9 read after write");
    addr[3] = mkAddr(0, 3, 0); step("R9 ordered read a");
    addr[3] = mkAddr(1, 4, 0); step("R9 ordered read b");
    idle();

    // Random mix: R2 R5 R6 R7 R8; losing ports keep their request.
    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < NP; p++) begin
        if (!(req[p] && !lastGnt[p])) begin
          req[p] = ($urandom % 4) != 0;
          we[p] = $urandom % 2;
          addr[p] = mkAddr($urandom % 4, $urandom % 8, $urandom % 8);
          wdata[p] = {$urandom, $urandom};
          be[p] = 8'($urandom);
        end
      end
      step("R2 R5 R6 R7 random");
    end
    idle();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule